// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block is a small non-blocking time-division-multiplexed switch. Several serial input lines each carry a repeating frame of 8-bit channels. The block captures every channel into a two-bank sample store. On every output line, in every channel slot, it sends the sample of whichever input channel the processor has chosen for that slot.

Each routing entry picks one of two timing rules. The lowest-latency rule sends the newest sample. The frame-aligned rule always sends the previous frame's sample, so a group of channels carrying one wide data connection keeps its internal order. Each entry can also float its output slot. A processor port reads and writes the sample store, the routing table and the per-line input skew. One command loads every routing entry at once.

All lines share one bit clock and one frame pulse. One bit moves per clock. A frame is `NCH*8` bit periods long. `NCH` must be a power of two and `NS` must be at least 2.

Top module: `tsi_switch`

## Requirements
- R1: A low level on `fp_ni` at a rising edge sets the frame position to 0. Bit 0 of channel 0 is then sampled at the next edge. The position otherwise rises by one per clock and wraps from `NCH*8-1` to 0. Bits are MSB first, and bit position p is bit `7-(p mod 8)` of channel `p/8`.
- R2: Input line s has a skew register (CPU sel 2, address s). The bit sampled at frame position p is local bit `(p - skew) mod NCH*8` of that line.
- R3: Each completed input channel is written into the current bank at index `s*NCH+ch`. The current bank flips at every frame pulse, and the write at the pulse edge still lands in the old bank. The CPU reads the store with sel 0 and address `{bank, s, ch}`.
- R4: A routing entry with bit 5 set sends the sample from the bank that is not current during that output frame.
- R5: A routing entry with bit 5 clear sends the current-bank sample if its input channel completed at an edge earlier in the current frame than the edge that loads the output slot. Otherwise it sends the other bank's sample.
- R6: Output slot c covers frame positions `c*8..c*8+7`, MSB first. The bit for position p appears on `tx_o` after the edge that makes p the current position.
- R7: A routing entry with bit 6 clear holds `tx_oe_o` low and `tx_o` high for the whole slot.
- R8: One input channel may feed any number of output slots at the same time.
- R9: Routing entry layout is `{en[6], frame_aligned[5], src_line[4:3], src_ch[2:0]}`. It is written with sel 1 at address `{line, ch}`, and a write takes effect at the next frame pulse.
- R10: `cpu_fill_i` writes `cpu_wdata_i` into every routing entry in one cycle, and it wins over a single-entry write.
- R11: A read (`cpu_req_i` high, `cpu_we_i` low) returns its data on `cpu_rdata_o` after one edge. The data is the state before that edge.
- R12: A CPU write to the sample store (sel 0) lands at once. If a received channel hits the same entry in the same cycle, the received sample wins.
- R13: Reset clears all routing entries, samples and skews, sets the position to 0 and the bank to 0, and disables all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_ni | input | 1 | Frame pulse, active low, one clock |
| rx_i | input | NS | Serial input lines |
| tx_o | output | NS | Serial output lines, idle high |
| tx_oe_o | output | NS | Per-line drive enable for the pad tri-state |
| cpu_req_i | input | 1 | Access request |
| cpu_we_i | input | 1 | Write when high, read when low |
| cpu_sel_i | input | 2 | 0 sample store, 1 routing table, 2 skew |
| cpu_addr_i | input | 1+log2(NS*NCH) | Access address |
| cpu_wdata_i | input | DW | Write data |
| cpu_fill_i | input | 1 | Load all routing entries with write data |
| cpu_rdata_o | output | DW | Read data, one cycle after the request |

## Verification
Several properties are checked on every cycle. The position returns to zero after a pulse, the bank flips at each pulse, and the received flags are cleared at a pulse. The live routing table holds still between pulses, and an output enable changes only at a slot boundary. The bench runs a cycle-level reference model and compares every output line on every clock. Only this comparison can show the choice between the two banks in each timing rule, the effect of the skew on where channels land, the deferred activation of routing entries, and the collision priority on the sample store.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CONN = 2'd1,
    SEL_OFS  = 2'd2
  } cpu_sel_e;

  localparam int unsigned SMP_W = 8;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter  int unsigned NCH = 8,
  localparam int unsigned FB  = NCH * 8,
  localparam int unsigned PW  = $clog2(FB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_ni,
  output logic [PW-1:0] pos_o,
  output logic [PW-1:0] nxt_pos_o,
  output logic          bank_o,
  output logic          nxt_bank_o,
  output logic          fp_evt_o
);
  logic [PW-1:0] pos_q;
  logic          bank_q;

  assign fp_evt_o   = ~fp_ni;
  assign nxt_pos_o  = fp_evt_o ? '0 : ((pos_q == PW'(FB - 1)) ? '0 : pos_q + 1'b1);
  assign nxt_bank_o = bank_q ^ fp_evt_o;
  assign pos_o      = pos_q;
  assign bank_o     = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      pos_q  <= nxt_pos_o;
      bank_q <= nxt_bank_o;
    end
  end

  // R1
  fp_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> pos_q == '0);
  // R3
  bank_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> bank_q != $past(bank_q));
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
  parameter  int unsigned NCH = 8,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned PW  = CHW + 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PW-1:0]  pos_i,
  input  logic [PW-1:0]  ofs_i,
  input  logic           rx_i,
  output logic           we_o,
  output logic [CHW-1:0] ch_o,
  output logic [7:0]     smp_o
);
  logic [PW-1:0] lpos;
  logic [7:0]    sh_q;

  assign lpos  = pos_i - ofs_i;   // wraps: frame length is a power of two
  assign we_o  = &lpos[2:0];
  assign ch_o  = lpos[PW-1:3];
  assign smp_o = {sh_q[6:0], rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= smp_o;
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter  int unsigned NS  = 4,
  parameter  int unsigned NCH = 8,
  localparam int unsigned NE  = NS * NCH,
  localparam int unsigned EW  = $clog2(NE),
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fp_evt_i,
  input  logic                       bank_i,
  input  logic [NS-1:0]              rx_we_i,
  input  logic [NS-1:0][CHW-1:0]     rx_ch_i,
  input  logic [NS-1:0][7:0]         rx_smp_i,
  input  logic                       cpu_we_i,
  input  logic [EW:0]                cpu_addr_i,
  input  logic [7:0]                 cpu_wdata_i,
  output logic [1:0][NE-1:0][7:0]    mem_o,
  output logic [NE-1:0]              seen_o
);
  logic [1:0][NE-1:0][7:0] mem_q;
  logic [NE-1:0]           seen_q;
  logic [NE-1:0]           set_vec;

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NS; s++)
      if (rx_we_i[s]) set_vec[EW'(s * NCH) | EW'(rx_ch_i[s])] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      seen_q <= '0;
    end else begin
      if (cpu_we_i) mem_q[cpu_addr_i[EW]][cpu_addr_i[EW-1:0]] <= cpu_wdata_i;
      // receive path assigned last: wins on collision
      for (int s = 0; s < NS; s++)
        if (rx_we_i[s]) mem_q[bank_i][EW'(s * NCH) | EW'(rx_ch_i[s])] <= rx_smp_i[s];
      seen_q <= fp_evt_i ? '0 : (seen_q | set_vec);
    end
  end

  assign mem_o  = mem_q;
  assign seen_o = seen_q;

  // R5
  seen_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_evt_i |=> seen_q == '0);
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter  int unsigned NE = 32,
  parameter  int unsigned CW = 7,
  localparam int unsigned EW = $clog2(NE)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fp_evt_i,
  input  logic                   wr_i,
  input  logic [EW-1:0]          addr_i,
  input  logic [CW-1:0]          data_i,
  input  logic                   fill_i,
  output logic [NE-1:0][CW-1:0]  pend_o,
  output logic [NE-1:0][CW-1:0]  act_o
);
  logic [NE-1:0][CW-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (fill_i)    pend_q         <= {NE{data_i}};
      else if (wr_i) pend_q[addr_i] <= data_i;
      if (fp_evt_i)  act_q          <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_evt_i |=> $stable(act_q));
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
  parameter  int unsigned NS  = 4,
  parameter  int unsigned NCH = 8,
  localparam int unsigned NE  = NS * NCH,
  localparam int unsigned EW  = $clog2(NE),
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned PW  = CHW + 3,
  localparam int unsigned CW  = EW + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PW-1:0]             nxt_pos_i,
  input  logic                      fp_evt_i,
  input  logic                      nxt_bank_i,
  input  logic [NCH-1:0][CW-1:0]    pend_i,
  input  logic [NCH-1:0][CW-1:0]    act_i,
  input  logic [1:0][NE-1:0][7:0]   mem_i,
  input  logic [NE-1:0]             seen_i,
  output logic                      tx_o,
  output logic                      oe_o
);
  logic           ld, fresh, rd_bank;
  logic [CHW-1:0] ch;
  logic [CW-1:0]  ent;
  logic [EW-1:0]  src;
  logic [7:0]     smp, sh_q;
  logic           bit_q, oe_q;

  assign ld      = nxt_pos_i[2:0] == 3'd0;
  assign ch      = nxt_pos_i[PW-1:3];
  assign ent     = fp_evt_i ? pend_i[ch] : act_i[ch];
  assign src     = ent[EW-1:0];
  assign fresh   = ~fp_evt_i & seen_i[src];
  assign rd_bank = (ent[EW] | ~fresh) ? ~nxt_bank_i : nxt_bank_i;
  assign smp     = mem_i[rd_bank][src];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (ld) begin
      bit_q <= smp[7];
      sh_q  <= {smp[6:0], 1'b0};
      oe_q  <= ent[EW+1];
    end else begin
      bit_q <= sh_q[7];
      sh_q  <= {sh_q[6:0], 1'b0};
    end
  end

  assign tx_o = oe_q ? bit_q : 1'b1;
  assign oe_o = oe_q;

  // R7
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(oe_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter  int unsigned NS  = 4,
  parameter  int unsigned NCH = 8,
  localparam int unsigned NE  = NS * NCH,
  localparam int unsigned EW  = $clog2(NE),
  localparam int unsigned STW = $clog2(NS),
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned PW  = CHW + 3,
  localparam int unsigned CW  = EW + 2,
  localparam int unsigned AW  = EW + 1,
  localparam int unsigned DW  = (CW > 8) ? CW : 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_ni,
  input  logic [NS-1:0] rx_i,
  output logic [NS-1:0] tx_o,
  output logic [NS-1:0] tx_oe_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [1:0]    cpu_sel_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_fill_i,
  output logic [DW-1:0] cpu_rdata_o
);
  import tsi_pkg::*;

  logic [PW-1:0]            pos, nxt_pos;
  logic                     bank, nxt_bank, fp_evt;
  logic [NS-1:0][PW-1:0]    ofs_q;
  logic [NS-1:0]            rx_we;
  logic [NS-1:0][CHW-1:0]   rx_ch;
  logic [NS-1:0][7:0]       rx_smp;
  logic [1:0][NE-1:0][7:0]  mem;
  logic [NE-1:0]            seen;
  logic [NE-1:0][CW-1:0]    pend, act;
  logic [DW-1:0]            rdata_q;
  cpu_sel_e                 sel;
  logic                     wr_data, wr_conn, wr_ofs, rd;

  assign sel     = cpu_sel_e'(cpu_sel_i);
  assign rd      = cpu_req_i & ~cpu_we_i;
  assign wr_data = cpu_req_i & cpu_we_i & (sel == SEL_DATA);
  assign wr_conn = cpu_req_i & cpu_we_i & (sel == SEL_CONN);
  assign wr_ofs  = cpu_req_i & cpu_we_i & (sel == SEL_OFS);

  tsi_timing #(.NCH(NCH)) u_tim (
    .clk_i, .rst_ni, .fp_ni,
    .pos_o(pos), .nxt_pos_o(nxt_pos), .bank_o(bank),
    .nxt_bank_o(nxt_bank), .fp_evt_o(fp_evt)
  );

  for (genvar s = 0; s < NS; s++) begin : g_rx
    tsi_rx_lane #(.NCH(NCH)) u_rx (
      .clk_i, .rst_ni, .pos_i(pos), .ofs_i(ofs_q[s]), .rx_i(rx_i[s]),
      .we_o(rx_we[s]), .ch_o(rx_ch[s]), .smp_o(rx_smp[s])
    );
  end

  tsi_data_mem #(.NS(NS), .NCH(NCH)) u_dmem (
    .clk_i, .rst_ni, .fp_evt_i(fp_evt), .bank_i(bank),
    .rx_we_i(rx_we), .rx_ch_i(rx_ch), .rx_smp_i(rx_smp),
    .cpu_we_i(wr_data), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i[7:0]),
    .mem_o(mem), .seen_o(seen)
  );

  tsi_conn_mem #(.NE(NE), .CW(CW)) u_cmem (
    .clk_i, .rst_ni, .fp_evt_i(fp_evt), .wr_i(wr_conn),
    .addr_i(cpu_addr_i[EW-1:0]), .data_i(cpu_wdata_i[CW-1:0]), .fill_i(cpu_fill_i),
    .pend_o(pend), .act_o(act)
  );

  for (genvar o = 0; o < NS; o++) begin : g_tx
    tsi_tx_lane #(.NS(NS), .NCH(NCH)) u_tx (
      .clk_i, .rst_ni, .nxt_pos_i(nxt_pos), .fp_evt_i(fp_evt), .nxt_bank_i(nxt_bank),
      .pend_i(pend[o*NCH +: NCH]), .act_i(act[o*NCH +: NCH]),
      .mem_i(mem), .seen_i(seen), .tx_o(tx_o[o]), .oe_o(tx_oe_o[o])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ofs) ofs_q[cpu_addr_i[STW-1:0]] <= cpu_wdata_i[PW-1:0];
      if (rd) begin
        unique case (sel)
          SEL_DATA: rdata_q <= DW'(mem[cpu_addr_i[EW]][cpu_addr_i[EW-1:0]]);
          SEL_CONN: rdata_q <= DW'(pend[cpu_addr_i[EW-1:0]]);
          SEL_OFS:  rdata_q <= DW'(ofs_q[cpu_addr_i[STW-1:0]]);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata_o = rdata_q;
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int NS = 4, NCH = 8, FB = NCH * 8, NE = NS * NCH, AW = 6, DW = 8;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic          rst_ni, fp_ni, cpu_req_i, cpu_we_i, cpu_fill_i;
  logic [NS-1:0] rx_i, tx_o, tx_oe_o;
  logic [1:0]    cpu_sel_i;
  logic [AW-1:0] cpu_addr_i;
  logic [DW-1:0] cpu_wdata_i, cpu_rdata_o;

  tsi_switch u_dut (
    .clk_i(clk), .rst_ni, .fp_ni, .rx_i, .tx_o, .tx_oe_o,
    .cpu_req_i, .cpu_we_i, .cpu_sel_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_fill_i, .cpu_rdata_o
  );

  int total = 0, bad = 0, cyc = 0;
  int unsigned m_mem[2][NE], m_pend[NE], m_act[NE], m_ofs[NS], m_rxsh[NS], m_txsh[NS];
  bit m_seen[NE], m_oe[NS], m_bank, rd_chk, fp_on;
  int unsigned m_pos, exp_rd;
  logic [NS-1:0] exp_tx, exp_oe;
  string tx_tag = "R13", rd_tag = "R11", rd_tag_nx = "R11";
  bit c_req, c_we, c_fill;
  int unsigned c_sel, c_addr, c_wd;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  function automatic void model();
    bit fp = !fp_ni;
    int unsigned nxt = fp ? 0 : (m_pos + 1) % FB;
    bit nb = fp ? !m_bank : m_bank;
    bit we[NS];
    int unsigned idx[NS], smp[NS];
    int unsigned old_pend[NE];
    for (int i = 0; i < NE; i++) old_pend[i] = m_pend[i];
    // R6 / R4 / R5 output slot load
    for (int o = 0; o < NS; o++) begin
      if (nxt % 8 == 0) begin
        int unsigned e = fp ? m_pend[o*NCH + nxt/8] : m_act[o*NCH + nxt/8];
        int unsigned src = e & 31;
        bit cmode = (e >> 5) & 1;
        bit cur = fp ? 1'b0 : m_seen[src];
        m_oe[o] = (e >> 6) & 1;
        m_txsh[o] = (cmode || !cur) ? m_mem[!nb][src] : m_mem[nb][src];
      end
      exp_oe[o] = m_oe[o];
      exp_tx[o] = m_oe[o] ? ((m_txsh[o] >> 7) & 1) : 1'b1;
      m_txsh[o] = (m_txsh[o] << 1) & 255;
    end
    // R11 read
    if (cpu_req_i && !cpu_we_i) begin
      rd_chk = 1;
      rd_tag = rd_tag_nx;
      case (cpu_sel_i)
        0: exp_rd = m_mem[(cpu_addr_i >> 5) & 1][cpu_addr_i & 31];
        1: exp_rd = m_pend[cpu_addr_i & 31];
        2: exp_rd = m_ofs[cpu_addr_i & 3];
        default: exp_rd = 0;
      endcase
    end
    // R1 / R2 receive
    for (int s = 0; s < NS; s++) begin
      int unsigned l = (m_pos + FB - m_ofs[s]) % FB;
      smp[s] = ((m_rxsh[s] << 1) | rx_i[s]) & 255;
      m_rxsh[s] = smp[s];
      we[s] = (l % 8 == 7);
      idx[s] = s * NCH + l / 8;
    end
    if (cpu_req_i && cpu_we_i && cpu_sel_i == 0) m_mem[(cpu_addr_i >> 5) & 1][cpu_addr_i & 31] = cpu_wdata_i;
    for (int s = 0; s < NS; s++) if (we[s]) m_mem[m_bank][idx[s]] = smp[s];   // R12 receive wins
    if (fp) for (int i = 0; i < NE; i++) m_seen[i] = 0;
    else for (int s = 0; s < NS; s++) if (we[s]) m_seen[idx[s]] = 1;
    if (cpu_req_i && cpu_we_i && cpu_sel_i == 2) m_ofs[cpu_addr_i & 3] = cpu_wdata_i & (FB - 1);
    if (cpu_fill_i) for (int i = 0; i < NE; i++) m_pend[i] = cpu_wdata_i & 127;
    else if (cpu_req_i && cpu_we_i && cpu_sel_i == 1) m_pend[cpu_addr_i & 31] = cpu_wdata_i & 127;
    if (fp) for (int i = 0; i < NE; i++) m_act[i] = old_pend[i];
    m_bank = nb;
    m_pos = nxt;
  endfunction

  task automatic drive();
    fp_ni = !(fp_on && (cyc % FB == FB - 1));
    rx_i = NS'($urandom);
    cpu_req_i = c_req; cpu_we_i = c_we; cpu_fill_i = c_fill;
    cpu_sel_i = 2'(c_sel); cpu_addr_i = AW'(c_addr); cpu_wdata_i = DW'(c_wd);
    model();
    cyc++;
  endtask

  task automatic check();
    for (int s = 0; s < NS; s++) begin
      total++;
      if (tx_o[s] !== exp_tx[s] || tx_oe_o[s] !== exp_oe[s]) begin
        bad++;
        $display("FAIL %s line %0d cyc %0d: tx=%b oe=%b expected tx=%b oe=%b",
                 tx_tag, s, cyc, tx_o[s], tx_oe_o[s], exp_tx[s], exp_oe[s]);
      end
    end
    if (rd_chk) begin
      total++;
      if (cpu_rdata_o !== DW'(exp_rd)) begin
        bad++;
        $display("FAIL %s read cyc %0d: got %0h expected %0h", rd_tag, cyc, cpu_rdata_o, exp_rd);
      end
    end
    rd_chk = 0;
  endtask

  task automatic step();
    @(negedge clk);
    check();
    drive();
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic cpu_io(bit we, int unsigned sel, int unsigned addr, int unsigned wd, string tag);
    c_req = 1; c_we = we; c_sel = sel; c_addr = addr; c_wd = wd; rd_tag_nx = tag;
    step();
    c_req = 0; c_we = 0;
  endtask

  task automatic fill(int unsigned v);
    c_fill = 1; c_wd = v;
    step();
    c_fill = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_71a0));
    rst_ni = 0; fp_ni = 1; rx_i = '0; cpu_req_i = 0; cpu_we_i = 0; cpu_fill_i = 0;
    cpu_sel_i = '0; cpu_addr_i = '0; cpu_wdata_i = '0;
    c_req = 0; c_we = 0; c_fill = 0; c_sel = 0; c_addr = 0; c_wd = 0; fp_on = 1;
    for (int i = 0; i < NE; i++) begin m_mem[0][i] = 0; m_mem[1][i] = 0; m_pend[i] = 0; m_act[i] = 0; m_seen[i] = 0; end
    for (int s = 0; s < NS; s++) begin m_ofs[s] = 0; m_rxsh[s] = 0; m_txsh[s] = 0; m_oe[s] = 0; end
    m_pos = 0; m_bank = 0; exp_tx = '1; exp_oe = '0; rd_chk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 state during reset
    total++;
    if (tx_oe_o !== '0 || tx_o !== '1) begin
      bad++; $display("FAIL R13 reset: tx=%b oe=%b expected tx=1111 oe=0000", tx_o, tx_oe_o);
    end
    rst_ni = 1;
    drive();
    cpu_io(0, 1, 5, 0, "R13");
    cpu_io(0, 0, 37, 0, "R13");

    // R10 fill, variable mode from line 0 ch 0, then R1/R6 serial timing
    tx_tag = "R10";
    fill(8'h40);
    c_req = 1; c_we = 1; c_sel = 1; c_addr = 3; c_wd = 8'h7f; c_fill = 1; c_wd = 8'h41;
    step();
    c_req = 0; c_we = 0; c_fill = 0;
    for (int i = 0; i < NE; i += 7) cpu_io(0, 1, i, 0, "R10");
    tx_tag = "R1,R6";
    run(2 * FB);

    // R8 one source to every slot, frame aligned
    tx_tag = "R8,R4";
    fill(8'h60 | (1 << 3) | 3);
    run(3 * FB);
    // R5 low latency from an early source channel
    tx_tag = "R5";
    fill(8'h40 | (2 << 3) | 0);
    run(3 * FB);

    // R9 random entries written mid-frame
    tx_tag = "R9,R4,R5,R7";
    for (int i = 0; i < NE; i++) cpu_io(1, 1, i, $urandom % 128, "R9");
    repeat (5 * FB) begin
      if ($urandom % 6 == 0) cpu_io(1, 1, $urandom % NE, $urandom % 128, "R9");
      else step();
    end
    for (int i = 0; i < NE; i += 5) cpu_io(0, 1, i, 0, "R9");

    // R2 per-line skew, including the largest value
    tx_tag = "R2";
    cpu_io(1, 2, 0, FB - 1, "R2");
    for (int s = 1; s < NS; s++) cpu_io(1, 2, s, $urandom % FB, "R2");
    for (int s = 0; s < NS; s++) cpu_io(0, 2, s, 0, "R11");
    run(4 * FB);

    // R3 sample store readback in both banks
    tx_tag = "R3";
    for (int a = 0; a < 2 * NE; a++) cpu_io(0, 0, a, 0, "R3");

    // R12 CPU writes into the store under live traffic, then readback
    tx_tag = "R12";
    repeat (3 * FB) begin
      if ($urandom % 3 == 0) cpu_io(1, 0, $urandom % (2 * NE), $urandom % 256, "R12");
      else if ($urandom % 2 == 0) cpu_io(0, 0, $urandom % (2 * NE), 0, "R12");
      else step();
    end

    // R7 all slots disabled
    tx_tag = "R7";
    fill(8'h20);
    run(2 * FB);
    step();
    summary();
    $finish;
  end
endmodule